// File: doc/BRIEF.md
# Pattern Lookup Fetch Unit

This unit carries out the table-lookup instruction of a small 4-bit controller. On a start strobe it takes the current program counter, the accumulator, the B register, the carry flag and a 3-bit operand. From these it builds a temporary ROM address. It then reads one ROM word and writes the data byte of that word into the destinations chosen by two command bits in the same word.

The program counter is only borrowed to form the address. The unit has no path that writes it back, so after the lookup the normal incrementer simply moves on to the next instruction. The lookup takes two machine cycles:

- **First cycle:** the unit drives the formed address and a read enable to a synchronous ROM.
- **Second cycle:** the ROM word is on the read port. The selected write enables are high for that one clock, and a done pulse marks the end.

The program counter is 11 bits wide: one bank bit, then four page bits, then six low address bits.

Top module: `pattern_lookup`

## Requirements
- R1: The six low bits of the lookup address equal {acc[3:0], breg[1:0]}, with acc in bits 5:2.
- R2: The four page bits of the lookup address (bits 9:6) equal the PC page bits OR {breg[3], breg[2], carry, operand[1] | operand[0]}, with breg[3] in the MSB.
- R3: The bank bit of the lookup address (bit 10) equals pc[10] OR operand[2]. Code in bank 1 therefore always reads bank 1, and code in bank 0 reads the bank given by operand[2].
- R4: In the clock cycle after an accepted start, rom_en is high and rom_addr holds the formed address. In every other cycle rom_en is low and rom_addr is zero.
- R5: If bit 8 of the ROM word is 1, then in the second cycle after start acc_we and b_we are high, with acc_wd = word[7:4] and b_wd = word[3:0].
- R6: If bit 9 of the ROM word is 1, then in the second cycle after start r2_we and r3_we are high, with r2_wd = word[7:4] and r3_wd = word[3:0].
- R7: If both command bits are 1, both register pairs are written in that cycle. If both are 0, no write enable rises and all write data outputs stay zero.
- R8: busy is high for exactly the two cycles of a lookup. done is high for exactly one cycle, the second one.
- R9: A start seen while busy is high is ignored. No new read follows once the current lookup ends.
- R10: After reset the unit is idle: busy, done, rom_en and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one lookup |
| operand | input | 3 | Instruction operand p |
| pc | input | 11 | Current program counter {bank, page, low} |
| acc | input | 4 | Accumulator value |
| breg | input | 4 | B register value |
| carry | input | 1 | Carry flag |
| rom_addr | output | 11 | ROM read address |
| rom_en | output | 1 | ROM read enable |
| rom_rdata | input | 10 | ROM word, valid one cycle after the read |
| acc_we | output | 1 | Accumulator write enable |
| acc_wd | output | 4 | Accumulator write data |
| b_we | output | 1 | B register write enable |
| b_wd | output | 4 | B register write data |
| r2_we | output | 1 | I/O register R2 write enable |
| r2_wd | output | 4 | I/O register R2 write data |
| r3_we | output | 1 | I/O register R3 write enable |
| r3_wd | output | 4 | I/O register R3 write data |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle end-of-lookup pulse |

## Verification
The formed address and the read enable are due one clock edge after the edge that samples start. The write enables, their data and done are due one edge later, once the bench ROM model has registered its word. By the third edge the unit must be idle again. The bench raises start at a falling edge and samples at the next three falling edges, so each reading falls midway between the edges that produce it. It sweeps every accumulator, B, carry and operand value under several PC values, so every mix of command bits occurs.

// File: rtl/pattern_lookup_pkg.sv
package pattern_lookup_pkg;

    localparam int BANK_W = 1;
    localparam int PAGE_W = 4;
    localparam int LOW_W  = 6;
    localparam int PC_W   = BANK_W + PAGE_W + LOW_W;
    localparam int NIB_W  = 4;
    localparam int OPND_W = 3;
    localparam int WORD_W = 2 + 2 * NIB_W;
    localparam int BSEL_W = LOW_W - NIB_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
        logic [LOW_W-1:0]  low;
    } rom_addr_t;

    typedef struct packed {
        logic             to_io;
        logic             to_acc;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } rom_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2
    } seq_state_t;

    function automatic rom_addr_t form_lookup_addr(
        input rom_addr_t         cur_pc,
        input logic [NIB_W-1:0]  a_val,
        input logic [NIB_W-1:0]  b_val,
        input logic              cy,
        input logic [OPND_W-1:0] p
    );
        rom_addr_t r;
        r.low  = {a_val, b_val[BSEL_W-1:0]};
        r.page = cur_pc.page | {b_val[NIB_W-1:BSEL_W], cy, p[1] | p[0]};
        r.bank = cur_pc.bank | p[OPND_W-1];
        return r;
    endfunction

endpackage

// File: rtl/plk_addr_former.sv
module plk_addr_former
    import pattern_lookup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  rom_addr_t         cur_pc,
    input  logic [NIB_W-1:0]  a_val,
    input  logic [NIB_W-1:0]  b_val,
    input  logic              cy,
    input  logic [OPND_W-1:0] p,
    output rom_addr_t         addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= form_lookup_addr(cur_pc, a_val, b_val, cy, p);
        end
    end

    // Bank of the captured address follows the PC bank and operand MSB
    p_bank_or_r3: assert property (@(posedge clk) disable iff (rst)
        capture |=> addr_q.bank == ($past(cur_pc.bank) | $past(p[OPND_W-1])));

endmodule

// File: rtl/plk_sequencer.sv
module plk_sequencer
    import pattern_lookup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic fetch,
    output logic load,
    output logic busy
);

    seq_state_t state_q, state_d;

    assign accept = start && (state_q == ST_IDLE);
    assign fetch  = (state_q == ST_FETCH);
    assign load   = (state_q == ST_LOAD);
    assign busy   = fetch || load;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    p_accept_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> fetch);

    p_fetch_then_load_r8: assert property (@(posedge clk) disable iff (rst)
        fetch |=> load);

    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> !busy);

endmodule

// File: rtl/plk_dest_decode.sv
module plk_dest_decode
    import pattern_lookup_pkg::*;
(
    input  logic             load,
    input  rom_word_t        word,
    output logic             acc_we,
    output logic [NIB_W-1:0] acc_wd,
    output logic             b_we,
    output logic [NIB_W-1:0] b_wd,
    output logic             r2_we,
    output logic [NIB_W-1:0] r2_wd,
    output logic             r3_we,
    output logic [NIB_W-1:0] r3_wd
);

    logic core_go, io_go;

    always_comb begin
        core_go = load && word.to_acc;
        io_go   = load && word.to_io;
        acc_we  = core_go;
        b_we    = core_go;
        r2_we   = io_go;
        r3_we   = io_go;
        acc_wd  = core_go ? word.hi : '0;
        b_wd    = core_go ? word.lo : '0;
        r2_wd   = io_go   ? word.hi : '0;
        r3_wd   = io_go   ? word.lo : '0;
    end

    always_comb begin
        if (!load) begin
            p_quiet_outside_load_r7: assert (!acc_we && !b_we && !r2_we && !r3_we);
        end
    end

endmodule

// File: rtl/pattern_lookup.sv
module pattern_lookup
    import pattern_lookup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPND_W-1:0] operand,
    input  logic [PC_W-1:0]   pc,
    input  logic [NIB_W-1:0]  acc,
    input  logic [NIB_W-1:0]  breg,
    input  logic              carry,
    output logic [PC_W-1:0]   rom_addr,
    output logic              rom_en,
    input  logic [WORD_W-1:0] rom_rdata,
    output logic              acc_we,
    output logic [NIB_W-1:0]  acc_wd,
    output logic              b_we,
    output logic [NIB_W-1:0]  b_wd,
    output logic              r2_we,
    output logic [NIB_W-1:0]  r2_wd,
    output logic              r3_we,
    output logic [NIB_W-1:0]  r3_wd,
    output logic              busy,
    output logic              done
);

    logic      accept, fetch, load;
    rom_addr_t addr_q;
    rom_word_t word;

    assign word = rom_word_t'(rom_rdata);

    plk_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .fetch  (fetch),
        .load   (load),
        .busy   (busy)
    );

    plk_addr_former u_addr (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .cur_pc  (rom_addr_t'(pc)),
        .a_val   (acc),
        .b_val   (breg),
        .cy      (carry),
        .p       (operand),
        .addr_q  (addr_q)
    );

    plk_dest_decode u_dec (
        .load   (load),
        .word   (word),
        .acc_we (acc_we),
        .acc_wd (acc_wd),
        .b_we   (b_we),
        .b_wd   (b_wd),
        .r2_we  (r2_we),
        .r2_wd  (r2_wd),
        .r3_we  (r3_we),
        .r3_wd  (r3_wd)
    );

    assign rom_en   = fetch;
    assign rom_addr = fetch ? PC_W'(addr_q) : '0;
    assign done     = load;

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_read_then_done_r8: assert property (@(posedge clk) disable iff (rst)
        rom_en |=> done);

    p_we_needs_done_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_we || r2_we) |-> done);

    p_low_field_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> rom_addr[LOW_W-1:0] == {$past(acc), $past(breg[BSEL_W-1:0])});

endmodule

// File: tb/pattern_lookup_test.sv
module pattern_lookup_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  operand;
    logic [10:0] pc;
    logic [3:0]  acc, breg;
    logic        carry;
    logic [10:0] rom_addr;
    logic        rom_en;
    logic [9:0]  rom_rdata;
    logic        acc_we, b_we, r2_we, r3_we;
    logic [3:0]  acc_wd, b_wd, r2_wd, r3_wd;
    logic        busy, done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pattern_lookup uut (
        .clk(clk), .rst(rst), .start(start), .operand(operand), .pc(pc),
        .acc(acc), .breg(breg), .carry(carry), .rom_addr(rom_addr),
        .rom_en(rom_en), .rom_rdata(rom_rdata), .acc_we(acc_we), .acc_wd(acc_wd),
        .b_we(b_we), .b_wd(b_wd), .r2_we(r2_we), .r2_wd(r2_wd),
        .r3_we(r3_we), .r3_wd(r3_wd), .busy(busy), .done(done)
    );

    function automatic logic [9:0] rom_fn(input logic [10:0] a);
        return 10'((a * 29) ^ (a >> 3) ^ 11'h15A);
    endfunction

    always_ff @(posedge clk) begin
        if (rom_en) rom_rdata <= rom_fn(rom_addr);
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [10:0] p_c, input logic [3:0] a, input logic [3:0] b,
                          input logic c, input logic [2:0] p, input logic hold);
        logic [10:0] ea;
        logic [9:0]  w;
        logic        core, io;
        ea = {p_c[10] | p[2],
              p_c[9:6] | {b[3], b[2], c, p[1] | p[0]},
              a, b[1:0]};
        w    = rom_fn(ea);
        core = w[8];
        io   = w[9];
        @(negedge clk);
        pc = p_c; acc = a; breg = b; carry = c; operand = p; start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        else operand = ~p;
        // first cycle: address out (R1, R2, R3, R4)
        chk(rom_addr[5:0] == ea[5:0], "R1 low field", int'(rom_addr[5:0]), int'(ea[5:0]));
        chk(rom_addr[9:6] == ea[9:6], "R2 page field", int'(rom_addr[9:6]), int'(ea[9:6]));
        chk(rom_addr[10] == ea[10], "R3 bank bit", int'(rom_addr[10]), int'(ea[10]));
        chk(rom_en && busy && !done, "R4/R8 first cycle", int'({rom_en, busy, done}), 3'b110);
        @(negedge clk);
        // second cycle: loads (R5, R6, R7, R8)
        chk(acc_we == core && b_we == core, "R5 acc/B enables",
            int'({acc_we, b_we}), int'({core, core}));
        chk(acc_wd == (core ? w[7:4] : 4'h0) && b_wd == (core ? w[3:0] : 4'h0),
            "R5 acc/B data", int'({acc_wd, b_wd}), int'(core ? w[7:0] : 8'h0));
        chk(r2_we == io && r3_we == io, "R6 R2/R3 enables",
            int'({r2_we, r3_we}), int'({io, io}));
        chk(r2_wd == (io ? w[7:4] : 4'h0) && r3_wd == (io ? w[3:0] : 4'h0),
            "R6/R7 R2/R3 data", int'({r2_wd, r3_wd}), int'(io ? w[7:0] : 8'h0));
        chk(done && busy && !rom_en, "R8 second cycle", int'({done, busy, rom_en}), 3'b110);
        @(negedge clk);
        start = 1'b0;
        // third cycle: idle again, held start ignored (R9)
        chk(!busy && !done && !rom_en && !acc_we && !r2_we, "R9 idle after lookup",
            int'({busy, done, rom_en, acc_we, r2_we}), 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] pcs [4];
        pcs[0] = 11'h000; pcs[1] = 11'h2AB; pcs[2] = 11'h415; pcs[3] = 11'h7C0;
        rst = 1'b1; start = 1'b0; operand = '0; pc = '0; acc = '0; breg = '0; carry = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !rom_en && !acc_we && !b_we && !r2_we && !r3_we,
            "R10 reset idle", int'({busy, done, rom_en, acc_we, b_we, r2_we, r3_we}), 0);
        chk(rom_addr == 11'h0, "R4 address zero when idle", int'(rom_addr), 0);
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int c = 0; c < 2; c++)
                        for (int p = 0; p < 8; p++)
                            lookup(pcs[k], 4'(a), 4'(b), 1'(c), 3'(p), 1'b0);
        // R9: start held high through both busy cycles is ignored
        lookup(11'h000, 4'h3, 4'h9, 1'b0, 3'd0, 1'b1);
        lookup(11'h3C4, 4'hF, 4'h2, 1'b1, 3'd5, 1'b1);
        @(negedge clk);
        chk(!busy && !rom_en, "R9 no extra lookup", int'({busy, rom_en}), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule